// File: doc/BRIEF.md
# Memory-Mapped ATA Register Bridge

This block sits between a host bus and the parallel register interface of an ATA disk controller. It gives the device a 4 KiB memory window in which each register lives on its own 16-byte slot. Byte accesses reach the command-block registers and the control register. A read of the control slot returns the alternate status. Halfword and word accesses reach only the data port. Their byte lanes are reversed in both directions, so a big-endian host sees little-endian device data in its natural order. Any access that falls on no register returns all ones at the access width on a read and has no effect on a write.

Every host access takes one request cycle. Read data comes back on the following cycle with a one-cycle valid pulse. The device-side read and write strobes are combinational from the request and fire once per access, so a register whose read has side effects, such as the status or data port, is touched exactly once. When reset is released, the block drives a single-cycle bus reset toward the device.

Top module: `mmio_ata_bridge`

## Requirements
- R1: Only address bits [11:4] select a register (the slot index); bits [3:0] never change which register is reached or the data returned.
- R2: A byte access (size 0) at slot index 1 to 7 strobes device register number 1 to 7 once; a read returns the device's low byte in rdata[7:0] with rdata[31:8] zero, and a write presents wdata[7:0] zero-extended on dev_wdata.
- R3: A byte access at slot index 8 or 22 reaches device register 8: a write goes to the device control register, and a read returns the alternate status byte from the same register number.
- R4: A byte read at any other slot index returns 0x000000FF with no device strobe; a byte write there produces no device strobe.
- R5: A halfword access (size 1) at slot index 0 reaches device register 0 with bytes swapped: a write drives {16'h0, wdata[7:0], wdata[15:8]}, and a read returns {16'h0, dev_rdata[7:0], dev_rdata[15:8]}.
- R6: A word access (size 2) at slot index 0 reaches device register 0 with all four bytes reversed in both directions.
- R7: A halfword or word access at a nonzero slot index strobes nothing; reads return 0x0000FFFF for a halfword and 0xFFFFFFFF for a word.
- R8: Size code 3 is reserved: it strobes nothing, and a read returns 0xFFFFFFFF.
- R9: rvalid pulses high for exactly the cycle after each read request, with the result on rdata, and stays low after writes.
- R10: Each mapped access gives exactly one device strobe, read or write but never both, and no strobe appears without a request.
- R11: dev_bus_rst is high for exactly one cycle, the cycle that follows the first clock edge after reset is released.
- R12: While rst_n is low, rvalid and rdata are zero and no device strobe fires, even with a request present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| addr | input | 12 | Byte offset inside the window |
| wdata | input | 32 | Host write data, right-aligned |
| rdata | output | 32 | Read result, right-aligned |
| rvalid | output | 1 | One-cycle pulse when rdata holds a read result |
| dev_reg | output | 4 | Device register number (0 data, 1-7 command block, 8 control/alt status) |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_size | output | 2 | Size code of the current access |
| dev_wdata | output | 32 | Write data toward the device, lanes already swapped |
| dev_rdata | input | 32 | Device read data for dev_reg, valid while dev_rd is high |
| dev_bus_rst | output | 1 | Single-cycle bus reset toward the device |

## Verification
The bench sweeps every slot index with all four size codes for both reads and writes. Each access sets a different low nibble, so a decoder that let bits [3:0] leak into the index would strike the wrong register. The device model returns a value that changes with every read strobe. A bridge that strobed twice, or that used the wrong or unswapped byte lanes, would therefore return a value the bench does not expect. Both alias slots 8 and 22 are compared with neighbours such as 9, 21 and 23. The all-ones fill is checked at each width, because a design that reused one fill value for every size would return stray high bytes. The bus reset pulse is checked after the first reset and after a later one. A design that held the pulse, or raised it during reset, would fail there.

// File: rtl/mmab_pkg.sv
// Package: shared access-size encoding for the ATA register bridge.
// Assumes the host encodes size on two bits; code 3 is reserved.
package mmab_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;
endpackage

// File: rtl/mmab_decode.sv
// Module: slot decoder. Maps a slot index and access size to a device
// register number and a hit flag. Assumes the index has already been
// stripped of the stride bits; purely combinational.
module mmab_decode
    import mmab_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int SLOT_W    = 4,
    parameter int CMD_LO    = 1,
    parameter int CMD_HI    = 7,
    parameter int ALT_A     = 8,
    parameter int ALT_B     = 22,
    parameter int CTRL_SLOT = 8,
    parameter int DATA_IDX  = 0
) (
    input  acc_size_e         size,
    input  logic [IDX_W-1:0]  idx,
    output logic              hit,
    output logic [SLOT_W-1:0] slot
);
    // Route byte accesses to command/control slots, wide ones to the data port.
    always_comb begin
        hit  = 1'b0;
        slot = '0;
        unique case (size)
            SZ_BYTE: begin
                if (idx >= IDX_W'(CMD_LO) && idx <= IDX_W'(CMD_HI)) begin
                    hit  = 1'b1;
                    slot = SLOT_W'(idx);
                end else if (idx == IDX_W'(ALT_A) || idx == IDX_W'(ALT_B)) begin
                    hit  = 1'b1;
                    slot = SLOT_W'(CTRL_SLOT);
                end
            end
            SZ_HALF, SZ_WORD: begin
                if (idx == IDX_W'(DATA_IDX)) begin
                    hit  = 1'b1;
                    slot = SLOT_W'(DATA_IDX);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mmab_swap.sv
// Module: byte-lane reverser. Output byte i is input byte BYTES-1-i.
// Assumes whole bytes; purely combinational wiring.
module mmab_swap #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    // One assignment per byte lane.
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign dout[8*i +: 8] = din[8*(BYTES-1-i) +: 8];
    end
endmodule

// File: rtl/mmab_rst_pulse.sv
// Module: bus reset pulse generator. Arms while rst_n is low and emits a
// single-cycle pulse on the first clock after release.
module mmab_rst_pulse (
    input  logic clk,
    input  logic rst_n,
    output logic pulse
);
    logic armed;

    // Arm during reset, fire once after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
            pulse <= 1'b0;
        end else begin
            pulse <= armed;
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/mmio_ata_bridge.sv
// Module: memory-mapped ATA register bridge (top). Decodes a host access
// into a single device strobe, reverses byte lanes for wide data-port
// accesses, and returns all-ones at access width for unmapped reads.
// Assumes one request per cycle at most and a combinational device read path.
module mmio_ata_bridge
    import mmab_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int STRIDE_LG = 4,
    parameter int DATA_W    = 32,
    parameter int SLOT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [SLOT_W-1:0] dev_reg,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [1:0]        dev_size,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_bus_rst
);
    localparam int IDX_W   = ADDR_W - STRIDE_LG;
    localparam int HALF_W  = DATA_W / 2;
    localparam int BYTE_W  = 8;

    acc_size_e          sz;
    logic [IDX_W-1:0]   idx;
    logic [STRIDE_LG-1:0] lane_unused;
    logic               hit;
    logic [SLOT_W-1:0]  slot;
    logic               active;
    logic [HALF_W-1:0]  wr_sw16, rd_sw16;
    logic [DATA_W-1:0]  wr_sw32, rd_sw32;
    logic [DATA_W-1:0]  wr_fmt, rd_fmt, miss_val;

    assign sz          = acc_size_e'(size);
    assign idx         = addr[ADDR_W-1:STRIDE_LG];
    assign lane_unused = addr[STRIDE_LG-1:0];
    assign active      = req & rst_n;

    mmab_decode #(.IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_dec (
        .size (sz),
        .idx  (idx),
        .hit  (hit),
        .slot (slot)
    );

    mmab_swap #(.BYTES(HALF_W/8)) u_sw_wr16 (.din(wdata[HALF_W-1:0]),     .dout(wr_sw16));
    mmab_swap #(.BYTES(DATA_W/8)) u_sw_wr32 (.din(wdata),                 .dout(wr_sw32));
    mmab_swap #(.BYTES(HALF_W/8)) u_sw_rd16 (.din(dev_rdata[HALF_W-1:0]), .dout(rd_sw16));
    mmab_swap #(.BYTES(DATA_W/8)) u_sw_rd32 (.din(dev_rdata),             .dout(rd_sw32));

    mmab_rst_pulse u_rst (.clk(clk), .rst_n(rst_n), .pulse(dev_bus_rst));

    // Format write data, read data and miss fill by access size.
    always_comb begin
        unique case (sz)
            SZ_BYTE: begin
                wr_fmt   = DATA_W'(wdata[BYTE_W-1:0]);
                rd_fmt   = DATA_W'(dev_rdata[BYTE_W-1:0]);
                miss_val = DATA_W'({BYTE_W{1'b1}});
            end
            SZ_HALF: begin
                wr_fmt   = DATA_W'(wr_sw16);
                rd_fmt   = DATA_W'(rd_sw16);
                miss_val = DATA_W'({HALF_W{1'b1}});
            end
            default: begin
                wr_fmt   = wr_sw32;
                rd_fmt   = rd_sw32;
                miss_val = '1;
            end
        endcase
    end

    // Device-side strobes fire in the request cycle, once per access.
    assign dev_rd    = active & ~we & hit;
    assign dev_wr    = active & we & hit;
    assign dev_reg   = hit ? slot : '0;
    assign dev_size  = size;
    assign dev_wdata = dev_wr ? wr_fmt : '0;

    // Capture the read result and raise rvalid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= req & ~we;
            if (req & ~we) begin
                rdata <= hit ? rd_fmt : miss_val;
            end
        end
    end
endmodule

// File: rtl/mmab_checker.sv
// Module: protocol checker for the ATA register bridge, bound to the top.
// Assumes the default 32-bit data width and size encoding from the package.
module mmab_checker #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [1:0]        size,
    input logic [IDX_W-1:0]  idx,
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid,
    input logic              dev_rd,
    input logic              dev_wr,
    input logic              dev_bus_rst
);
    logic byte_mapped;
    assign byte_mapped = (idx >= IDX_W'(1) && idx <= IDX_W'(8)) || idx == IDX_W'(22);

    assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rd && dev_wr));
    assert_strobe_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd || dev_wr) |-> req);
    assert_rvalid_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rvalid);
    assert_rvalid_only_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(req && !we));
    assert_wide_off_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (size == 2'd1 || size == 2'd2) && idx != '0) |-> !(dev_rd || dev_wr));
    assert_rsvd_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && size == 2'd3) |-> !(dev_rd || dev_wr));
    assert_byte_miss_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && size == 2'd0 && !byte_mapped) |=> (rdata == DATA_W'(8'hFF)));
    assert_bus_rst_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dev_bus_rst |=> !dev_bus_rst);
endmodule

bind mmio_ata_bridge mmab_checker #(.IDX_W(ADDR_W - STRIDE_LG), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .we          (we),
    .size        (size),
    .idx         (addr[ADDR_W-1:STRIDE_LG]),
    .rdata       (rdata),
    .rvalid      (rvalid),
    .dev_rd      (dev_rd),
    .dev_wr      (dev_wr),
    .dev_bus_rst (dev_bus_rst)
);

// File: tb/mmio_ata_bridge_tb.sv
`timescale 1ns/1ps
module mmio_ata_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, dev_wdata, dev_rdata;
    logic        rvalid, dev_rd, dev_wr, dev_bus_rst;
    logic [3:0]  dev_reg;
    logic [1:0]  dev_size;

    int n_chk = 0, n_bad = 0;
    int rd_n = 0, wr_n = 0;
    logic [3:0]  rd_cnt = '0;
    logic [3:0]  last_rd_reg = '0, last_wr_reg = '0;
    logic [31:0] last_wr_data = '0;

    always #2 clk = ~clk;

    mmio_ata_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .dev_reg(dev_reg),
        .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_size(dev_size),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_bus_rst(dev_bus_rst)
    );

    // Device model: value depends on register and on a per-read counter.
    function automatic logic [31:0] dev_val(logic [3:0] r, logic [3:0] c);
        return {4'hA, r, 4'h5, c, 4'hC, r, 4'h3, c};
    endfunction
    assign dev_rdata = dev_val(dev_reg, rd_cnt);

    // Record device strobes.
    always @(posedge clk) begin
        if (rst_n) begin
            if (dev_rd) begin
                rd_n        <= rd_n + 1;
                rd_cnt      <= rd_cnt + 4'd1;
                last_rd_reg <= dev_reg;
            end
            if (dev_wr) begin
                wr_n         <= wr_n + 1;
                last_wr_reg  <= dev_reg;
                last_wr_data <= dev_wdata;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input bit w, input logic [1:0] sz, input logic [11:0] a,
                          input logic [31:0] wd);
        int rd0, wr0;
        logic [3:0] c0, er;
        logic [7:0] ix;
        logic [31:0] v, exp;
        bit mapped;
        string tag;
        ix = a[11:4];
        mapped = 1'b0;
        er = 4'd0;
        if (sz == 2'd0) begin
            if (ix >= 8'd1 && ix <= 8'd7) begin mapped = 1'b1; er = ix[3:0]; tag = "R1 R2"; end
            else if (ix == 8'd8 || ix == 8'd22) begin mapped = 1'b1; er = 4'd8; tag = "R1 R3"; end
            else tag = "R1 R4";
        end else if (sz == 2'd3) tag = "R8";
        else if (ix == 8'd0) begin mapped = 1'b1; tag = (sz == 2'd1) ? "R5" : "R6"; end
        else tag = "R7";
        @(negedge clk);
        req = 1'b1; we = w; size = sz; addr = a; wdata = wd;
        rd0 = rd_n; wr0 = wr_n; c0 = rd_cnt;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        if (!w) begin
            v = dev_val(er, c0);
            if (mapped) begin
                case (sz)
                    2'd0: exp = {24'h0, v[7:0]};
                    2'd1: exp = {16'h0, v[7:0], v[15:8]};
                    default: exp = {v[7:0], v[15:8], v[23:16], v[31:24]};
                endcase
            end else begin
                case (sz)
                    2'd0: exp = 32'h0000_00FF;
                    2'd1: exp = 32'h0000_FFFF;
                    default: exp = 32'hFFFF_FFFF;
                endcase
            end
            check({tag, " rdata"}, rdata, exp);
            check("R9 rvalid after read", {31'h0, rvalid}, 32'd1);
            check("R10 read strobes", rd_n - rd0, mapped ? 32'd1 : 32'd0);
            check("R10 no write on read", wr_n - wr0, 32'd0);
            if (mapped) check({tag, " read reg"}, {28'h0, last_rd_reg}, {28'h0, er});
        end else begin
            check("R9 no rvalid on write", {31'h0, rvalid}, 32'd0);
            check({tag, " write strobes"}, wr_n - wr0, mapped ? 32'd1 : 32'd0);
            check("R10 no read on write", rd_n - rd0, 32'd0);
            if (mapped) begin
                case (sz)
                    2'd0: exp = {24'h0, wd[7:0]};
                    2'd1: exp = {16'h0, wd[7:0], wd[15:8]};
                    default: exp = {wd[7:0], wd[15:8], wd[23:16], wd[31:24]};
                endcase
                check({tag, " write data"}, last_wr_data, exp);
                check({tag, " write reg"}, {28'h0, last_wr_reg}, {28'h0, er});
            end
        end
    endtask

    initial begin
        // R12: reset state, request present during reset.
        req = 1'b1; size = 2'd0; addr = 12'h010;
        repeat (3) @(negedge clk);
        check("R12 rvalid in reset", {31'h0, rvalid}, 32'd0);
        check("R12 rdata in reset", rdata, 32'd0);
        check("R12 no strobe in reset", {30'h0, dev_rd, dev_wr}, 32'd0);
        check("R11 no pulse in reset", {31'h0, dev_bus_rst}, 32'd0);
        req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 pulse after release", {31'h0, dev_bus_rst}, 32'd1);
        @(negedge clk);
        check("R11 pulse ends", {31'h0, dev_bus_rst}, 32'd0);

        // Full sweep: every slot, every size, read and write; low nibble varies (R1).
        for (int ix = 0; ix < 256; ix++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [11:0] a;
                    a = {ix[7:0], 4'((ix * 7 + sz * 5 + w * 3) & 15)};
                    access(w[0], sz[1:0], a, {ix[7:0], 6'h0, sz[1:0], ~ix[7:0], 8'h5A ^ ix[7:0]});
                end
            end
        end

        // Second reset: pulse again, once.
        @(negedge clk); rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 no pulse in second reset", {31'h0, dev_bus_rst}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 second pulse", {31'h0, dev_bus_rst}, 32'd1);
        @(negedge clk);
        check("R11 second pulse ends", {31'h0, dev_bus_rst}, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule